// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits in front of a word-wide memory shared by several hardware threads and gives them the two halves of an optimistic atomic update. A load-linked returns a word and records, for the issuing thread only, a reservation on the aligned 64-byte block containing that word. A later store-conditional from the same thread reaches memory only while that reservation survives. Its response tells the software whether it did: nonzero on success and zero on failure, so a retry loop needs nothing more than a branch on zero.

A reservation is lost when another thread writes anywhere in the block, when the owning thread takes a trap, when the thread issues another load-linked, when it issues any store-conditional, and when too many instructions retire between the pair. Requests arrive one per cycle on a single port tagged with the thread number. Each request gets one response one cycle later. The memory behind the monitor is a plain behavioural array.

Top module: `llsc_monitor`

## Requirements
- R1: After reset no thread holds a reservation and `rsp_valid` is low; a store-conditional issued before any load-linked returns 0.
- R2: Op codes on `req_op` are 0 = load, 1 = store, 2 = load-linked, 3 = store-conditional. Addresses are byte addresses of aligned 32-bit words. Every accepted request produces `rsp_valid` high in the following cycle. Load and load-linked return the stored word, a store writes the word and returns 0.
- R3: A store-conditional from a thread whose reservation is valid and covers the addressed block writes the word and returns 1.
- R4: A store-conditional without a matching valid reservation returns 0 and leaves memory unchanged.
- R5: The reservation granule is the aligned 64-byte block (address bits above bit 5). A store-conditional to another word in the reserved block succeeds, and a foreign store to any word of the block clears the reservation.
- R6: Stores from other threads to a different block, and stores from the owning thread itself, leave a reservation intact.
- R7: Every store-conditional clears the issuing thread's reservation, whether it succeeds or fails.
- R8: A pulse on the thread's bit of `trap_i` clears its reservation. A store-conditional from a thread in the same cycle as its own trap fails.
- R9: A new load-linked replaces the thread's earlier reservation: the old block no longer succeeds, the new one does.
- R10: With `MAX_GAP` = 16, a reservation survives up to 16 pulses on the thread's bit of `retire_i` after the load-linked; the 17th clears it.
- R11: A successful store-conditional clears, in the same cycle, every other thread's reservation on that block. A failed store-conditional clears no other thread's reservation, and reservations on other blocks are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Operation code (see R2) |
| req_tid | input | 2 | Issuing thread number |
| req_addr | input | 10 | Byte address, word aligned |
| req_wdata | input | 32 | Store data |
| trap_i | input | 4 | Per-thread trap taken this cycle |
| retire_i | input | 4 | Per-thread instruction retired this cycle |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | 32 | Read data, store-conditional result, or 0 for a store |

## Verification
The assertions check several properties on every cycle. A trap, a store-conditional or a matching foreign write always leaves the thread's reservation invalid one cycle later. A load-linked always leaves it valid on the requested block. The gap counter never exceeds its limit while a reservation is held. Every request is answered one cycle later, and a store-conditional answers only 0 or 1. Interactions between threads can only be shown by the bench's scenarios, which compare every response against a behavioural model. These include a winner's store-conditional defeating a second thread, a failed store-conditional leaving other reservations alone, the exact 16-versus-17 retire boundary, and the data actually left in memory after a suppressed store.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_LL    = 2'd2,
    OP_SC    = 2'd3
  } llsc_op_e;
endpackage

// File: rtl/llsc_mem_array.sv
module llsc_mem_array #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 256,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store_q [WORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      store_q[idx] <= wdata;
    end
  end

  assign rdata = store_q[idx];
endmodule

// File: rtl/llsc_resv_slot.sv
module llsc_resv_slot #(
  parameter int TAG_W   = 4,
  parameter int MAX_GAP = 16,
  localparam int CNT_W  = $clog2(MAX_GAP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trap_i,
  input  logic             retire_i,
  input  logic             ll_i,
  input  logic             sc_i,
  input  logic             ext_wr_i,
  input  logic [TAG_W-1:0] req_tag_i,
  output logic             resv_valid_o,
  output logic [TAG_W-1:0] resv_tag_o
);
  logic             valid_q, valid_d;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic [CNT_W-1:0] gap_q, gap_d;
  logic             upd_en;
  logic             snoop_hit;

  assign snoop_hit = ext_wr_i && valid_q && (req_tag_i == tag_q);
  assign upd_en    = trap_i || ll_i || sc_i || snoop_hit || (retire_i && valid_q);

  always_comb begin
    valid_d = valid_q;
    tag_d   = tag_q;
    gap_d   = gap_q;
    if (trap_i) begin
      valid_d = 1'b0;
    end else if (ll_i) begin
      valid_d = 1'b1;
      tag_d   = req_tag_i;
      gap_d   = '0;
    end else if (sc_i) begin
      valid_d = 1'b0;
    end else if (snoop_hit) begin
      valid_d = 1'b0;
    end else if (retire_i && valid_q) begin
      if (gap_q == CNT_W'(MAX_GAP)) begin
        valid_d = 1'b0;
      end else begin
        gap_d = gap_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      gap_q   <= '0;
    end else if (upd_en) begin
      valid_q <= valid_d;
      tag_q   <= tag_d;
      gap_q   <= gap_d;
    end
  end

  assign resv_valid_o = valid_q;
  assign resv_tag_o   = tag_q;

  AST_TRAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    trap_i |=> !resv_valid_o); // R8
  AST_LL_RESERVES: assert property (@(posedge clk) disable iff (!rst_n)
    (ll_i && !trap_i) |=> (resv_valid_o && resv_tag_o == $past(req_tag_i))); // R9
  AST_SC_DROPS_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_i && !ll_i) |=> !resv_valid_o); // R7
  AST_SNOOP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_wr_i && resv_valid_o && req_tag_i == resv_tag_o && !ll_i) |=> !resv_valid_o); // R5
  AST_GAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    resv_valid_o |-> (gap_q <= CNT_W'(MAX_GAP))); // R10
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int NTHREADS = 4,
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 32,
  parameter int BLK_BYTES = 64,
  parameter int MAX_GAP  = 16,
  localparam int TID_W   = $clog2(NTHREADS),
  localparam int OFF_W   = $clog2(DATA_W / 8),
  localparam int BLK_W   = $clog2(BLK_BYTES),
  localparam int TAG_W   = ADDR_W - BLK_W,
  localparam int IDX_W   = ADDR_W - OFF_W,
  localparam int WORDS   = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [TID_W-1:0]  req_tid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [NTHREADS-1:0] trap_i,
  input  logic [NTHREADS-1:0] retire_i,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  import llsc_pkg::*;

  llsc_op_e          op;
  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic              is_ll, is_sc, is_st, is_ld;
  logic              sc_ok;
  logic              mem_we;
  logic [DATA_W-1:0] mem_rdata;
  logic              resv_valid [NTHREADS];
  logic [TAG_W-1:0]  resv_tag   [NTHREADS];
  logic              rsp_valid_q, rsp_valid_d;
  logic [DATA_W-1:0] rsp_data_q, rsp_data_d;

  assign op      = llsc_op_e'(req_op);
  assign req_tag = req_addr[ADDR_W-1:BLK_W];
  assign req_idx = req_addr[ADDR_W-1:OFF_W];
  assign is_ld   = req_valid && (op == OP_LOAD);
  assign is_st   = req_valid && (op == OP_STORE);
  assign is_ll   = req_valid && (op == OP_LL);
  assign is_sc   = req_valid && (op == OP_SC);

  assign sc_ok  = resv_valid[req_tid] && (resv_tag[req_tid] == req_tag) && !trap_i[req_tid];
  assign mem_we = is_st || (is_sc && sc_ok);

  llsc_mem_array #(
    .DATA_W (DATA_W),
    .WORDS  (WORDS)
  ) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .idx   (req_idx),
    .wdata (req_wdata),
    .rdata (mem_rdata)
  );

  for (genvar g = 0; g < NTHREADS; g++) begin : g_slot
    logic mine;
    assign mine = (req_tid == TID_W'(g));
    llsc_resv_slot #(
      .TAG_W   (TAG_W),
      .MAX_GAP (MAX_GAP)
    ) u_slot (
      .clk          (clk),
      .rst_n        (rst_n),
      .trap_i       (trap_i[g]),
      .retire_i     (retire_i[g]),
      .ll_i         (is_ll && mine),
      .sc_i         (is_sc && mine),
      .ext_wr_i     (mem_we && !mine),
      .req_tag_i    (req_tag),
      .resv_valid_o (resv_valid[g]),
      .resv_tag_o   (resv_tag[g])
    );
  end

  always_comb begin
    rsp_valid_d = req_valid;
    rsp_data_d  = rsp_data_q;
    if (is_ld || is_ll) begin
      rsp_data_d = mem_rdata;
    end else if (is_st) begin
      rsp_data_d = '0;
    end else if (is_sc) begin
      rsp_data_d = DATA_W'(sc_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      if (req_valid) begin
        rsp_data_q <= rsp_data_d;
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;

  AST_ALIGNED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr[OFF_W-1:0] == '0)); // R2
  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R2
  AST_SC_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    is_sc |=> (rsp_data <= DATA_W'(1))); // R3
endmodule

// File: tb/llsc_monitor_tb.sv
module llsc_monitor_tb;
  localparam int MAXG = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = '0;
  logic [1:0]  req_tid = '0;
  logic [9:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  trap_i = '0;
  logic [3:0]  retire_i = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  logic [31:0] res;

  always #4 clk = ~clk;

  llsc_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_tid(req_tid), .req_addr(req_addr), .req_wdata(req_wdata),
    .trap_i(trap_i), .retire_i(retire_i),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data));

  // behavioural reference model
  logic [31:0] m_mem [int];
  bit          m_v   [4];
  int          m_tag [4];
  int          m_cnt [4];
  bit          e_valid = 0;
  bit          e_known = 0;
  logic [31:0] e_data = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < 4; t++) begin m_v[t] = 0; m_tag[t] = 0; m_cnt[t] = 0; end
      e_valid <= 0;
    end else begin
      int tag; int w; bit ok; bit wr;
      tag = int'(req_addr) / 64;
      w   = int'(req_addr) / 4;
      ok  = 0; wr = 0;
      e_valid <= req_valid;
      if (req_valid) begin
        case (req_op)
          2'd0, 2'd2: begin
            e_known <= m_mem.exists(w);
            if (m_mem.exists(w)) e_data <= m_mem[w];
          end
          2'd1: begin e_known <= 1; e_data <= 0; wr = 1; end
          default: begin
            ok = m_v[req_tid] && m_tag[req_tid] == tag && !trap_i[req_tid];
            e_known <= 1; e_data <= ok ? 32'd1 : 32'd0; wr = ok;
          end
        endcase
        if (wr) m_mem[w] = req_wdata;
      end
      for (int t = 0; t < 4; t++) begin
        bit mine;
        mine = req_valid && req_tid == t;
        if (trap_i[t]) m_v[t] = 0;
        else if (mine && req_op == 2'd2) begin m_v[t] = 1; m_tag[t] = tag; m_cnt[t] = 0; end
        else if (mine && req_op == 2'd3) m_v[t] = 0;
        else if (wr && !mine && m_v[t] && m_tag[t] == tag) m_v[t] = 0;
        else if (retire_i[t] && m_v[t]) begin
          if (m_cnt[t] == MAXG) m_v[t] = 0; else m_cnt[t]++;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      n_checks++;
      if (rsp_valid !== e_valid) begin
        n_fail++;
        $display("FAIL R2 per-cycle rsp_valid act=%0b exp=%0b", rsp_valid, e_valid);
      end else if (e_valid && e_known) begin
        n_checks++;
        if (rsp_data !== e_data) begin
          n_fail++;
          $display("FAIL R2 per-cycle rsp_data act=%h exp=%h", rsp_data, e_data);
        end
      end
    end
  end

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input int tid, input int addr,
                       input logic [31:0] wd, input logic [3:0] trap, output logic [31:0] r);
    @(posedge clk); #1;
    req_valid = 1; req_op = op; req_tid = 2'(tid); req_addr = 10'(addr);
    req_wdata = wd; trap_i = trap;
    @(posedge clk); #1;
    r = rsp_data;
    req_valid = 0; trap_i = '0;
  endtask

  task automatic retire_n(input int tid, input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; retire_i = 4'(1 << tid);
    end
    @(posedge clk); #1; retire_i = '0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  localparam int A = 'h040, B = 'h080, C = 'h100;

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    check("R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
    issue(2'd1, 1, A, 32'h11, 0, res); check("R2 store returns 0", res, 0);
    issue(2'd3, 0, A, 32'hAA, 0, res); check("R1 SC before any LL", res, 0);
    issue(2'd0, 2, A, 0, 0, res);      check("R4 memory kept after failed SC", res, 32'h11);
    issue(2'd1, 1, B, 32'h22, 0, res);
    issue(2'd0, 3, B, 0, 0, res);      check("R2 load data", res, 32'h22);
    issue(2'd1, 1, C, 32'h77, 0, res);
    issue(2'd3, 0, B, 32'h99, 0, res); check("R4 SC no reservation", res, 0);
    issue(2'd0, 0, B, 0, 0, res);      check("R4 memory unchanged", res, 32'h22);
    // R3
    issue(2'd2, 0, A, 0, 0, res);      check("R2 LL returns data", res, 32'h11);
    issue(2'd3, 0, A, 32'h33, 0, res); check("R3 SC success", res, 1);
    issue(2'd0, 0, A, 0, 0, res);      check("R3 SC wrote memory", res, 32'h33);
    // R5 granule
    issue(2'd2, 0, A, 0, 0, res);
    issue(2'd3, 0, A + 8, 32'h44, 0, res); check("R5 SC other word same block", res, 1);
    issue(2'd0, 0, A + 8, 0, 0, res);      check("R5 written word", res, 32'h44);
    issue(2'd2, 0, A, 0, 0, res);
    issue(2'd1, 1, A + 60, 32'h55, 0, res);
    issue(2'd3, 0, A, 32'h66, 0, res);     check("R5 foreign store in block clears", res, 0);
    issue(2'd0, 0, A, 0, 0, res);          check("R5 suppressed SC left memory", res, 32'h33);
    // R6
    issue(2'd2, 0, A, 0, 0, res);
    issue(2'd1, 1, B, 32'h23, 0, res);
    issue(2'd1, 0, A + 4, 32'h34, 0, res);
    issue(2'd3, 0, A, 32'h35, 0, res);     check("R6 unrelated and own stores keep it", res, 1);
    // R7
    issue(2'd2, 0, A, 0, 0, res);
    issue(2'd3, 0, A, 32'h36, 0, res);     check("R7 first SC", res, 1);
    issue(2'd3, 0, A, 32'h37, 0, res);     check("R7 second SC fails", res, 0);
    issue(2'd2, 0, A, 0, 0, res);
    issue(2'd3, 0, B, 32'h38, 0, res);     check("R7 failed SC wrong block", res, 0);
    issue(2'd3, 0, A, 32'h39, 0, res);     check("R7 reservation cleared by failed SC", res, 0);
    // R8
    issue(2'd2, 2, C, 0, 0, res);          check("R8 LL data", res, 32'h77);
    @(posedge clk); #1; trap_i = 4'b0100;
    @(posedge clk); #1; trap_i = '0;
    issue(2'd3, 2, C, 32'h78, 0, res);     check("R8 trap cleared", res, 0);
    issue(2'd2, 2, C, 0, 0, res);
    issue(2'd3, 2, C, 32'h79, 4'b0100, res); check("R8 trap same cycle as SC", res, 0);
    issue(2'd0, 2, C, 0, 0, res);          check("R8 memory unchanged", res, 32'h77);
    issue(2'd2, 2, C, 0, 0, res);
    issue(2'd3, 2, C, 32'h7A, 4'b0001, res); check("R8 other thread trap ignored", res, 1);
    // R9
    issue(2'd2, 0, A, 0, 0, res);
    issue(2'd2, 0, B, 0, 0, res);
    issue(2'd3, 0, A, 32'h40, 0, res);     check("R9 old block fails", res, 0);
    issue(2'd2, 0, A, 0, 0, res);
    issue(2'd2, 0, B, 0, 0, res);
    issue(2'd3, 0, B, 32'h41, 0, res);     check("R9 new block succeeds", res, 1);
    // R10
    issue(2'd2, 3, C, 0, 0, res);
    retire_n(3, MAXG);
    issue(2'd3, 3, C, 32'h80, 0, res);     check("R10 16 retires keep reservation", res, 1);
    issue(2'd2, 3, C, 0, 0, res);
    retire_n(3, MAXG + 1);
    issue(2'd3, 3, C, 32'h81, 0, res);     check("R10 17th retire clears", res, 0);
    // R11
    issue(2'd2, 0, A, 0, 0, res);
    issue(2'd2, 1, A + 4, 0, 0, res);
    issue(2'd2, 2, B, 0, 0, res);
    issue(2'd3, 1, A + 4, 32'h90, 0, res); check("R11 winner SC", res, 1);
    issue(2'd3, 0, A, 32'h91, 0, res);     check("R11 loser SC fails", res, 0);
    issue(2'd3, 2, B, 32'h92, 0, res);     check("R11 other block unaffected", res, 1);
    issue(2'd2, 0, A, 0, 0, res);
    issue(2'd3, 1, A, 32'h93, 0, res);     check("R11 SC without reservation", res, 0);
    issue(2'd3, 0, A, 32'h94, 0, res);     check("R11 failed SC did not clear others", res, 1);
    issue(2'd0, 3, A, 0, 0, res);          check("R11 final memory", res, 32'h94);
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule